// File: doc/BRIEF.md
# Scaler Phase Position Generator

This block produces the source sampling position for one axis of an image resampler. It is used once per row sequence or once per column sequence. It holds a fixed-point accumulator with 13 fractional bits. A restart pulse loads the accumulator with a programmed signed start offset. Each accepted advance emits one output sample and then adds a programmed unsigned increment. An increment of 8192 means a 1:1 ratio. Values below 8192 upsample and values above 8192 downsample.

Each output sample carries two fields. The first is the signed integer source index. The second is a 4-bit filter phase, taken from the top fractional bits of the position. The start offset may be negative, which lets chroma siting place the first sample a quarter pixel (-2048) or a half pixel (-4096) before the first source pixel. In that case the index reads -1 and the phase is non-zero. Downstream logic clamps a negative index. The index is capped at the programmed last source index.

Advance requests come in on a valid/ready pair and samples leave on a valid/ready pair through a single output register. An advance is accepted when the register is empty or is being drained in the same cycle. While a sample is held with the output ready low, the advance ready is low, the held sample does not change and the accumulator does not move. The configuration pins and the restart pulse are plain and need no handshake.

Top module: `scl_phase_gen`

## Requirements
- R1: After reset the output valid is low, the advance ready is high and the accumulator holds 0.
- R2: A restart pulse loads the accumulator with the sign-extended start offset, so the next sample reports the start position.
- R3: Each accepted advance (advance valid and advance ready high) produces exactly one sample, valid on the next cycle. The sample reports the position held before the addition, so sample k after a restart has the position start + k*increment.
- R4: The index is the floor of position/8192 as a 13-bit two's-complement value, so a negative start gives a negative index (-2048 and -4096 both give -1).
- R5: The phase is bits 12 down to 9 of the position (the four most significant fractional bits), so -2048 gives phase 12 and -4096 gives phase 8.
- R6: When the floor of the position exceeds the last-source-index input, the index reads that last index and the phase reads 0.
- R7: When a restart and an accepted advance fall in the same cycle, that sample reports the start position and the following sample reports start + increment.
- R8: While output valid is high and output ready is low, the sample stays unchanged, advance ready is low and an offered advance is neither accepted nor accumulated.
- R9: When a sample is drained and no advance is accepted in that cycle, output valid falls on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 19 | Signed start offset, 13 fractional bits |
| cfg_inc | input | 16 | Unsigned increment per sample, 13 fractional bits |
| cfg_src_last | input | 12 | Last valid source index (size minus one) |
| restart | input | 1 | Line or frame start pulse |
| adv_valid | input | 1 | Request for one output sample |
| adv_ready | output | 1 | Advance can be accepted |
| o_valid | output | 1 | Sample present |
| o_ready | input | 1 | Consumer takes the sample |
| o_index | output | 13 | Signed integer source index |
| o_phase | output | 4 | Filter phase |

## Verification
The restart and the advance can fall in the same cycle. The bench provokes this by raising restart and advance valid on one edge after the accumulator has moved far from the start. It then checks that the sample reports the fresh start position rather than the old accumulator value, and that the next sample reports start + increment. The bench also provokes an advance offered during a stall. It judges that the stall did not advance the position by checking that the first sample after the drain equals start + increment.

// File: rtl/scl_pos_pkg.sv
package scl_pos_pkg;
  localparam int FRAC_W_DEF  = 13;
  localparam int PHASE_W_DEF = 4;
  localparam int IDX_W_DEF   = 12;
  localparam int INC_W_DEF   = 16;
  localparam int START_W_DEF = 19;

  // accumulator width: sign, one guard bit, integer part, fraction
  function automatic int acc_width(input int frac_w, input int idx_w);
    return frac_w + idx_w + 2;
  endfunction
endpackage

// File: rtl/scl_pos_accum.sv
module scl_pos_accum
  import scl_pos_pkg::*;
#(
  parameter int FRAC_W  = FRAC_W_DEF,
  parameter int IDX_W   = IDX_W_DEF,
  parameter int INC_W   = INC_W_DEF,
  parameter int START_W = START_W_DEF,
  localparam int ACC_W  = acc_width(FRAC_W, IDX_W)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic signed [START_W-1:0] start_val,
  input  logic        [INC_W-1:0]   inc_val,
  input  logic                      restart,
  input  logic                      step,
  output logic signed [ACC_W-1:0]   sample_pos
);
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] start_ext;
  logic signed [ACC_W:0]   sum_w;
  logic signed [ACC_W-1:0] sum_sat;
  logic                    ovf;

  assign start_ext  = {{(ACC_W-START_W){start_val[START_W-1]}}, start_val};
  // a restart in the same cycle as a step redirects that sample to the start
  assign sample_pos = restart ? start_ext : acc_q;

  assign sum_w   = {sample_pos[ACC_W-1], sample_pos}
                 + {{(ACC_W+1-INC_W){1'b0}}, inc_val};
  assign ovf     = sum_w[ACC_W] != sum_w[ACC_W-1];
  assign sum_sat = ovf ? ACC_MAX : sum_w[ACC_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (step) begin
      acc_q <= sum_sat;
    end else if (restart) begin
      acc_q <= start_ext;
    end
  end
endmodule

// File: rtl/scl_pos_quant.sv
module scl_pos_quant
  import scl_pos_pkg::*;
#(
  parameter int FRAC_W  = FRAC_W_DEF,
  parameter int PHASE_W = PHASE_W_DEF,
  parameter int IDX_W   = IDX_W_DEF,
  parameter bit SAT_EN  = 1'b1,
  localparam int ACC_W  = acc_width(FRAC_W, IDX_W),
  localparam int INT_W  = ACC_W - FRAC_W
) (
  input  logic signed [ACC_W-1:0] pos,
  input  logic        [IDX_W-1:0] src_last,
  output logic signed [IDX_W:0]   index,
  output logic        [PHASE_W-1:0] phase
);
  logic signed [INT_W-1:0] int_part;
  logic        [PHASE_W-1:0] raw_phase;

  assign int_part  = pos[ACC_W-1:FRAC_W];
  assign raw_phase = pos[FRAC_W-1 -: PHASE_W];

  generate
    if (SAT_EN) begin : g_sat
      logic signed [INT_W-1:0] limit;
      logic                    over;
      assign limit = {{(INT_W-IDX_W){1'b0}}, src_last};
      assign over  = int_part > limit;
      assign index = over ? {1'b0, src_last} : int_part[IDX_W:0];
      assign phase = over ? '0 : raw_phase;
    end else begin : g_wrap
      logic unused_last;
      assign unused_last = ^src_last;
      assign index = int_part[IDX_W:0];
      assign phase = raw_phase;
    end
  endgenerate
endmodule

// File: rtl/scl_pos_outreg.sv
module scl_pos_outreg #(
  parameter int DW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          o_ready,
  output logic          o_valid,
  output logic [DW-1:0] dout,
  output logic          can_load
);
  assign can_load = !o_valid || o_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      dout    <= '0;
    end else begin
      if (load) begin
        o_valid <= 1'b1;
        dout    <= din;
      end else if (o_ready) begin
        o_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import scl_pos_pkg::*;
#(
  parameter int FRAC_W  = FRAC_W_DEF,
  parameter int PHASE_W = PHASE_W_DEF,
  parameter int IDX_W   = IDX_W_DEF,
  parameter int INC_W   = INC_W_DEF,
  parameter int START_W = START_W_DEF,
  parameter bit SAT_EN  = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic signed [START_W-1:0] cfg_start,
  input  logic        [INC_W-1:0]   cfg_inc,
  input  logic        [IDX_W-1:0]   cfg_src_last,
  input  logic                      restart,
  input  logic                      adv_valid,
  output logic                      adv_ready,
  output logic                      o_valid,
  input  logic                      o_ready,
  output logic signed [IDX_W:0]     o_index,
  output logic        [PHASE_W-1:0] o_phase
);
  localparam int ACC_W = acc_width(FRAC_W, IDX_W);
  localparam int OUT_W = IDX_W + 1 + PHASE_W;

  logic                     step;
  logic signed [ACC_W-1:0]  pos;
  logic signed [IDX_W:0]    q_index;
  logic        [PHASE_W-1:0] q_phase;
  logic        [OUT_W-1:0]  q_bus;
  logic        [OUT_W-1:0]  r_bus;
  logic                     can_load;

  assign adv_ready = can_load;
  assign step      = adv_valid && can_load;

  scl_pos_accum #(
    .FRAC_W(FRAC_W), .IDX_W(IDX_W), .INC_W(INC_W), .START_W(START_W)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .start_val(cfg_start), .inc_val(cfg_inc),
    .restart(restart), .step(step), .sample_pos(pos)
  );

  scl_pos_quant #(
    .FRAC_W(FRAC_W), .PHASE_W(PHASE_W), .IDX_W(IDX_W), .SAT_EN(SAT_EN)
  ) u_quant (
    .pos(pos), .src_last(cfg_src_last), .index(q_index), .phase(q_phase)
  );

  assign q_bus = {q_index, q_phase};

  scl_pos_outreg #(.DW(OUT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(step), .din(q_bus), .o_ready(o_ready),
    .o_valid(o_valid), .dout(r_bus), .can_load(can_load)
  );

  assign o_index = r_bus[OUT_W-1:PHASE_W];
  assign o_phase = r_bus[PHASE_W-1:0];
endmodule

// File: rtl/scl_phase_gen_chk.sv
module scl_phase_gen_chk #(
  parameter int IDX_W   = 12,
  parameter int PHASE_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [IDX_W-1:0]     cfg_src_last,
  input logic                 adv_valid,
  input logic                 adv_ready,
  input logic                 o_valid,
  input logic                 o_ready,
  input logic signed [IDX_W:0] o_index,
  input logic [PHASE_W-1:0]   o_phase
);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && !o_ready |=> o_valid && $stable(o_index) && $stable(o_phase));

  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && !o_ready |-> !adv_ready);

  // R3
  sample_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_valid && adv_ready |=> o_valid);

  // R9
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && o_ready && !(adv_valid && adv_ready) |=> !o_valid);

  // R6
  index_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && $stable(cfg_src_last) |-> o_index <= $signed({1'b0, cfg_src_last}));
endmodule

bind scl_phase_gen scl_phase_gen_chk #(.IDX_W(IDX_W), .PHASE_W(PHASE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_src_last(cfg_src_last), .adv_valid(adv_valid),
  .adv_ready(adv_ready), .o_valid(o_valid), .o_ready(o_ready),
  .o_index(o_index), .o_phase(o_phase)
);

// File: tb/sim_scl_phase_gen.sv
`timescale 1ns/1ps
module sim_scl_phase_gen;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic signed [18:0] cfg_start = '0;
  logic [15:0]        cfg_inc = 16'd8192;
  logic [11:0]        cfg_src_last = 12'd40;
  logic               restart = 1'b0;
  logic               adv_valid = 1'b0;
  logic               adv_ready;
  logic               o_valid;
  logic               o_ready = 1'b1;
  logic signed [12:0] o_index;
  logic [3:0]         o_phase;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  scl_phase_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_inc(cfg_inc),
    .cfg_src_last(cfg_src_last), .restart(restart), .adv_valid(adv_valid),
    .adv_ready(adv_ready), .o_valid(o_valid), .o_ready(o_ready),
    .o_index(o_index), .o_phase(o_phase)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected sample from a position, per R4, R5, R6
  task automatic check_pos(input string req, input longint pos, input int last);
    longint ei = pos >>> 13;
    longint ep = (pos & 8191) >> 9;
    if (ei > last) begin
      ei = last;
      ep = 0;
    end
    check({req, " valid"}, longint'(o_valid), 1);
    check({req, " index"}, longint'(o_index), ei);
    check({req, " phase"}, longint'(o_phase), ep);
  endtask

  task automatic pulse_restart();
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
  endtask

  task automatic one_adv();
    @(negedge clk) adv_valid = 1'b1;
    @(negedge clk) adv_valid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int starts[4] = '{0, -2048, -4096, 3000};
    int incs[5] = '{8192, 4096, 12288, 5461, 16384};
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 o_valid", longint'(o_valid), 0);
    check("R1 adv_ready", longint'(adv_ready), 1);
    rst_n = 1'b1;
    // R1 accumulator at 0: first advance without restart reports 0
    one_adv();
    check_pos("R1", 0, 40);
    @(negedge clk);

    // R2 R3 R4 R5 R6 sweep
    foreach (starts[s]) begin
      foreach (incs[i]) begin
        cfg_start = 19'(starts[s]);
        cfg_inc = 16'(incs[i]);
        cfg_src_last = 12'd40;
        pulse_restart();
        for (int k = 0; k < 24; k++) begin
          one_adv();
          check_pos("R2 R3 R4 R5 R6", longint'(starts[s]) + longint'(k) * incs[i], 40);
        end
      end
    end

    // R6 small last index with 1:1 steps
    cfg_start = 19'sd1024; cfg_inc = 16'd8192; cfg_src_last = 12'd3;
    pulse_restart();
    for (int k = 0; k < 6; k++) begin
      one_adv();
      check_pos("R6", 1024 + longint'(k) * 8192, 3);
    end
    cfg_src_last = 12'd40;

    // R7 restart and advance in one cycle, after moving away
    cfg_start = -19'sd2048; cfg_inc = 16'd6000;
    pulse_restart();
    for (int k = 0; k < 5; k++) one_adv();
    @(negedge clk) begin restart = 1'b1; adv_valid = 1'b1; end
    @(negedge clk) begin restart = 1'b0; adv_valid = 1'b0; end
    check_pos("R7 same-cycle", -2048, 40);
    one_adv();
    check_pos("R7 next", -2048 + 6000, 40);

    // R8 stall: second advance offered while blocked
    cfg_start = 19'sd0; cfg_inc = 16'd12000;
    pulse_restart();
    @(negedge clk) begin o_ready = 1'b0; adv_valid = 1'b1; end
    @(negedge clk);
    check_pos("R8 held", 0, 40);
    check("R8 adv_ready", longint'(adv_ready), 0);
    @(negedge clk);
    check_pos("R8 stable", 0, 40);
    adv_valid = 1'b0;
    // R9 drain without a new advance
    o_ready = 1'b1;
    @(negedge clk);
    check("R9 o_valid", longint'(o_valid), 0);
    one_adv();
    check_pos("R8 no accumulation", 12000, 40);
    @(negedge clk);
    check("R9 idle", longint'(o_valid), 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule